// File: doc/BRIEF.md
# Power-Management Event and Control Register Block

This block holds the fixed power-management registers that system firmware and the operating system use for sleep control and wake events. Software reaches three 16-bit registers (event status, event enable, sleep/interrupt control) and a free-running timer through a 64-byte register window. A level interrupt output tells the host when an enabled event is pending.

A status write of one clears the matching bit. The timer raises its status bit each time the running count crosses the next power-of-two boundary. Clearing that bit arms the following boundary. A control write with the sleep-go bit set decodes a 3-bit sleep type. Type 0 requests power-off. Type 1 fakes a wake caused by the power button, requests a reset and latches a suspend-to-RAM indication. A separate legacy command byte can turn the interrupt-enable bit on or off, and can raise a one-cycle SMI pulse.

Register map by offset (low 6 bits only): 0x00 status, 0x02 enable, 0x04 control, 0x08 timer (32-bit reads only).

Top module: `pm_event_block`

## Requirements
- R1: After reset, status, enable and control read as zero, the timer reads zero and sci, smi_pulse, shutdown_req, reset_req and s3_ind are low.
- R2: Only reg_off[5:0] is decoded. A 16-bit access (acc32=0) maps 0x00 to status, 0x02 to enable and 0x04 to control. A 32-bit read (acc32=1) returns the timer only at 0x08. Every other read returns zero, and 32-bit writes change nothing. Read data appears on rdata one cycle after rd_stb.
- R3: The count rises by one on every clock with tick_en high and holds otherwise. A timer read returns its low TMR_OUT_W bits, zero-extended.
- R4: A status write clears every bit written as 1 and leaves the others.
- R5: Status bit 0 (timer) becomes set once the count is at least the overflow point, which is 2^WRAP_SHIFT after reset. Clearing a set bit 0 moves the point to (count + 2^WRAP_SHIFT) with the low WRAP_SHIFT bits cleared.
- R6: sci is high exactly when status AND enable has any of bits 0, 5, 8 or 10 set. Bit 15 (wake) never drives sci.
- R7: An enable write stores the value. A control write stores the value with bit 13 (sleep-go) forced to 0.
- R8: A control write with bit 13 set and bits 12:10 = 0 gives a one-cycle shutdown_req pulse.
- R9: Sleep type 1 sets status bits 15 and 8, gives a one-cycle reset_req pulse and sets s3_ind, which stays high until reset. Types 2 to 7 have no effect.
- R10: A pwrbtn_evt pulse sets status bit 8 only while enable bit 8 is set.
- R11: An apm_stb with command 0xF1 sets control bit 0 and with 0xF0 clears it. Other commands leave control unchanged.
- R12: smi_pulse is high for one cycle after every apm_stb seen while smi_allow is high, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_off | input | 8 | Byte offset of the access |
| wr_stb | input | 1 | Write strobe |
| rd_stb | input | 1 | Read strobe |
| acc32 | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access |
| wdata | input | 16 | Write data |
| rdata | output | 32 | Read data, registered |
| tick_en | input | 1 | Timer advance enable |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| apm_stb | input | 1 | Legacy command strobe |
| apm_cmd | input | 8 | Legacy command byte |
| smi_allow | input | 1 | Lets legacy commands raise SMI |
| sci | output | 1 | Level interrupt |
| smi_pulse | output | 1 | One-cycle SMI request |
| shutdown_req | output | 1 | One-cycle power-off request |
| reset_req | output | 1 | One-cycle reset request |
| s3_ind | output | 1 | Suspend-to-RAM indication |

## Verification
The bench builds the block with WRAP_SHIFT=6 and TMR_OUT_W=10 and keeps CNT_W=32. At these values the timer-status boundary comes every 64 ticks, so the bench can observe the first overflow, the re-arm after an aligned clear and the rounding after an unaligned clear within a few hundred cycles. The 10-bit timer view wraps after 1024 ticks, so the zero-extension and truncation of the timer read can also be observed.

// File: rtl/pm_event_block.sv
module pm_event_block #(
  parameter int CNT_W      = 32,
  parameter int TMR_OUT_W  = 24,
  parameter int WRAP_SHIFT = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_off,
  input  logic        wr_stb,
  input  logic        rd_stb,
  input  logic        acc32,
  input  logic [15:0] wdata,
  output logic [31:0] rdata,
  input  logic        tick_en,
  input  logic        pwrbtn_evt,
  input  logic        apm_stb,
  input  logic [7:0]  apm_cmd,
  input  logic        smi_allow,
  output logic        sci,
  output logic        smi_pulse,
  output logic        shutdown_req,
  output logic        reset_req,
  output logic        s3_ind
);
  localparam logic [CNT_W-1:0] STEP     = {{(CNT_W-1){1'b0}}, 1'b1} << WRAP_SHIFT;
  localparam logic [CNT_W-1:0] LOW_MASK = STEP - 1'b1;
  localparam logic [15:0]      SCI_SRC  = 16'h0521;
  localparam logic [15:0]      WAKE_SET = 16'h8100;
  localparam int               PWR_BIT  = 8;
  localparam int               GO_BIT   = 13;

  logic [CNT_W-1:0] cnt, ovf;
  logic [15:0] status_q, en_q, ctl_q, status_d, ctl_d, st_live, st_clr, st_set;
  logic [5:0]  off;
  logic        wr16, wr_st, wr_en, wr_ctl, slp_go, tmr_hit, rearm;
  logic [2:0]  slp_typ;
  logic        unused_hi;

  assign unused_hi = ^reg_off[7:6];
  assign off       = reg_off[5:0];
  assign wr16      = wr_stb & ~acc32;
  assign wr_st     = wr16 && off == 6'h00;
  assign wr_en     = wr16 && off == 6'h02;
  assign wr_ctl    = wr16 && off == 6'h04;
  assign slp_go    = wr_ctl & wdata[GO_BIT];
  assign slp_typ   = wdata[12:10];

  assign tmr_hit   = cnt >= ovf;
  assign st_live   = status_q | {15'b0, tmr_hit};
  assign rearm     = wr_st & wdata[0] & st_live[0];
  assign st_clr    = wr_st ? wdata : 16'h0;
  assign st_set    = ((pwrbtn_evt & en_q[PWR_BIT]) ? 16'h0100 : 16'h0) |
                     ((slp_go && slp_typ == 3'd1) ? WAKE_SET : 16'h0);
  assign status_d  = (st_live & ~st_clr) | st_set;

  assign sci = |(status_q & en_q & SCI_SRC);

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d         = wdata;
      ctl_d[GO_BIT] = 1'b0;
    end
    if (apm_stb && apm_cmd == 8'hF1) ctl_d[0] = 1'b1;
    else if (apm_stb && apm_cmd == 8'hF0) ctl_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt          <= '0;
      ovf          <= STEP;
      status_q     <= '0;
      en_q         <= '0;
      ctl_q        <= '0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      s3_ind       <= 1'b0;
      smi_pulse    <= 1'b0;
    end else begin
      if (tick_en) cnt <= cnt + 1'b1;
      if (rearm)   ovf <= (cnt + STEP) & ~LOW_MASK;
      status_q     <= status_d;
      if (wr_en) en_q <= wdata;
      ctl_q        <= ctl_d;
      shutdown_req <= slp_go && slp_typ == 3'd0;
      reset_req    <= slp_go && slp_typ == 3'd1;
      s3_ind       <= s3_ind | (slp_go && slp_typ == 3'd1);
      smi_pulse    <= apm_stb & smi_allow;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_stb) begin
      if (acc32) begin
        rdata <= (off == 6'h08) ? {{(32-TMR_OUT_W){1'b0}}, cnt[TMR_OUT_W-1:0]} : 32'h0;
      end else begin
        case (off)
          6'h00:   rdata <= {16'h0, st_live};
          6'h02:   rdata <= {16'h0, en_q};
          6'h04:   rdata <= {16'h0, ctl_q};
          default: rdata <= 32'h0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pm_event_block_chk.sv
module pm_event_block_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             apm_stb,
  input logic             smi_allow,
  input logic             sci,
  input logic             smi_pulse,
  input logic             shutdown_req,
  input logic             reset_req,
  input logic             s3_ind,
  input logic [CNT_W-1:0] cnt,
  input logic [15:0]      en_q,
  input logic [15:0]      ctl_q
);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt == $past(cnt) + 1'b1);
  assert_count_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
  assert_sci_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sci |-> (en_q & 16'h0521) != 16'h0);
  assert_go_bit_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[13]);
  assert_shutdown_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);
  assert_reset_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  assert_s3_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s3_ind |=> s3_ind);
  assert_reset_with_s3_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> s3_ind);
  assert_smi_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    smi_pulse |-> $past(apm_stb && smi_allow));
endmodule

bind pm_event_block pm_event_block_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .apm_stb(apm_stb),
  .smi_allow(smi_allow), .sci(sci), .smi_pulse(smi_pulse),
  .shutdown_req(shutdown_req), .reset_req(reset_req), .s3_ind(s3_ind),
  .cnt(cnt), .en_q(en_q), .ctl_q(ctl_q)
);

// File: tb/test_pm_event_block.sv
`timescale 1ns/1ps
module test_pm_event_block;
  localparam int TOW = 10;
  localparam int WS  = 6;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  reg_off = '0;
  logic        wr_stb = 0, rd_stb = 0, acc32 = 0, tick_en = 0, pwrbtn_evt = 0;
  logic        apm_stb = 0, smi_allow = 0;
  logic [15:0] wdata = '0;
  logic [7:0]  apm_cmd = '0;
  logic [31:0] rdata;
  logic        sci, smi_pulse, shutdown_req, reset_req, s3_ind;

  int unsigned n_chk = 0, n_bad = 0;
  logic [31:0] model_cnt = 0;
  logic [15:0] exp_ctl = 0;
  bit          done = 0;

  pm_event_block #(.CNT_W(32), .TMR_OUT_W(TOW), .WRAP_SHIFT(WS)) i_pm_event_block (
    .clk(clk), .rst_n(rst_n), .reg_off(reg_off), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .acc32(acc32), .wdata(wdata), .rdata(rdata), .tick_en(tick_en),
    .pwrbtn_evt(pwrbtn_evt), .apm_stb(apm_stb), .apm_cmd(apm_cmd),
    .smi_allow(smi_allow), .sci(sci), .smi_pulse(smi_pulse),
    .shutdown_req(shutdown_req), .reset_req(reset_req), .s3_ind(s3_ind));

  always #4 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) model_cnt <= 0;
    else if (tick_en) model_cnt <= model_cnt + 1;

  function automatic logic [31:0] tmr_view(input logic [31:0] c);
    return c & ((32'h1 << TOW) - 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr16(input logic [7:0] off, input logic [15:0] v, input bit wide = 0);
    reg_off = off; wdata = v; acc32 = wide; wr_stb = 1;
    @(negedge clk);
    wr_stb = 0; acc32 = 0;
  endtask

  task automatic rd(input logic [7:0] off, input bit wide, output logic [31:0] v);
    reg_off = off; acc32 = wide; rd_stb = 1;
    @(negedge clk);
    v = rdata; rd_stb = 0; acc32 = 0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic apm(input logic [7:0] c, input bit allow);
    apm_cmd = c; smi_allow = allow; apm_stb = 1;
    @(negedge clk);
    apm_stb = 0;
    chk("R12 smi pulse", {31'b0, smi_pulse}, {31'b0, allow});
    @(negedge clk);
    chk("R12 smi one cycle", {31'b0, smi_pulse}, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;

    rd(8'h00, 0, v); chk("R1 status", v, 0);
    rd(8'h02, 0, v); chk("R1 enable", v, 0);
    rd(8'h04, 0, v); chk("R1 control", v, 0);
    rd(8'h08, 1, v); chk("R1 timer", v, 0);
    chk("R1 outputs", {27'b0, sci, smi_pulse, shutdown_req, reset_req, s3_ind}, 0);

    wr16(8'h42, 16'h0100);
    rd(8'h02, 0, v); chk("R2 high offset bits ignored", v, 32'h0100);
    rd(8'h06, 0, v); chk("R2 unmapped 16-bit", v, 0);
    rd(8'h00, 1, v); chk("R2 32-bit read off timer", v, 0);
    rd(8'h08, 0, v); chk("R2 16-bit read of timer offset", v, 0);
    wr16(8'h02, 16'hFFFF, 1);
    rd(8'h02, 0, v); chk("R2 32-bit write ignored", v, 32'h0100);

    pwrbtn_evt = 1; @(negedge clk); pwrbtn_evt = 0;
    rd(8'h00, 0, v); chk("R10 button sets status", v, 32'h0100);
    chk("R6 sci from button", {31'b0, sci}, 1);
    wr16(8'h00, 16'h0100);
    rd(8'h00, 0, v); chk("R4 clear button", v, 0);
    chk("R6 sci drops", {31'b0, sci}, 0);
    wr16(8'h02, 16'h0000);
    pwrbtn_evt = 1; @(negedge clk); pwrbtn_evt = 0;
    rd(8'h00, 0, v); chk("R10 gated by enable", v, 0);

    wr16(8'h04, 16'h2000);
    chk("R8 shutdown pulse", {31'b0, shutdown_req}, 1);
    @(negedge clk);
    chk("R8 shutdown one cycle", {31'b0, shutdown_req}, 0);
    rd(8'h04, 0, v); chk("R7 go bit not stored", v, 0);

    wr16(8'h04, 16'h2800);
    chk("R9 type 2 no pulses", {29'b0, shutdown_req, reset_req, s3_ind}, 0);
    rd(8'h00, 0, v); chk("R9 type 2 no status", v, 0);
    rd(8'h04, 0, v); chk("R7 control stored", v, 32'h0800);

    wr16(8'h02, 16'h8000);
    wr16(8'h04, 16'h2401);
    chk("R9 reset pulse and s3", {30'b0, reset_req, s3_ind}, 3);
    @(negedge clk);
    chk("R9 reset one cycle, s3 held", {30'b0, reset_req, s3_ind}, 1);
    rd(8'h00, 0, v); chk("R9 wake and button set", v, 32'h8100);
    chk("R6 wake alone no sci", {31'b0, sci}, 0);
    wr16(8'h02, 16'h0100);
    chk("R6 button enabled sci", {31'b0, sci}, 1);
    wr16(8'h00, 16'h8000);
    rd(8'h00, 0, v); chk("R4 partial clear", v, 32'h0100);
    wr16(8'h00, 16'hFFFF);
    wr16(8'h02, 16'h0000);
    rd(8'h04, 0, v); chk("R7 sleep write stores rest", v, 32'h0401);
    exp_ctl = 16'h0401;

    apm(8'hF0, 0);
    rd(8'h04, 0, v); chk("R11 F0 clears", v, 32'h0400);
    apm(8'hF1, 1);
    rd(8'h04, 0, v); chk("R11 F1 sets", v, 32'h0401);
    apm(8'h55, 1);
    rd(8'h04, 0, v); chk("R11 other cmd no change", v, 32'h0401);

    ticks(63);
    rd(8'h00, 0, v); chk("R5 before first boundary", v, 0);
    ticks(1);
    rd(8'h00, 0, v); chk("R5 first boundary", v, 1);
    wr16(8'h02, 16'h0001);
    chk("R6 timer sci", {31'b0, sci}, 1);
    wr16(8'h00, 16'h0001);
    rd(8'h00, 0, v); chk("R5 cleared", v, 0);
    chk("R6 timer sci drops", {31'b0, sci}, 0);
    ticks(63);
    rd(8'h00, 0, v); chk("R5 just before rearm point", v, 0);
    ticks(1);
    rd(8'h00, 0, v); chk("R5 at rearm point 128", v, 1);
    ticks(10);
    c = model_cnt;
    chk("R3 model count sanity", c, 138);
    rd(8'h08, 1, v); chk("R3 timer read", v, tmr_view(c));
    wr16(8'h00, 16'h0001);
    ticks(191 - 138);
    rd(8'h00, 0, v); chk("R5 unaligned clear rounds, 191", v, 0);
    ticks(1);
    rd(8'h00, 0, v); chk("R5 unaligned clear rounds, 192", v, 1);
    ticks(1100);
    rd(8'h08, 1, v); chk("R3 timer truncation", v, tmr_view(model_cnt));
    wr16(8'h02, 16'h0000);

    for (int i = 0; i < 150; i++) begin
      int op;
      logic [15:0] r;
      op = $urandom % 4;
      r = 16'($urandom);
      case (op)
        0: begin
          for (int k = 0; k < int'($urandom % 40); k++) begin
            tick_en = 1'($urandom);
            @(negedge clk);
          end
          tick_en = 0;
          c = model_cnt;
          rd(8'h08, 1, v); chk("R3 random ticks", v, tmr_view(c));
        end
        1: begin
          wr16({2'($urandom), 6'h02}, r);
          rd({2'($urandom), 6'h02}, 0, v); chk("R7 enable random", v, {16'h0, r});
        end
        2: begin
          r[13] = 1'b0;
          wr16(8'h04, r);
          exp_ctl = r;
          rd(8'h04, 0, v); chk("R7 control random", v, {16'h0, r});
        end
        default: begin
          logic [7:0] cmd;
          cmd = 8'($urandom);
          if (cmd == 8'hF0 || cmd == 8'hF1) cmd = 8'h00;
          apm(cmd, 1'($urandom));
          rd(8'h04, 0, v); chk("R11 random cmd no change", v, {16'h0, exp_ctl});
        end
      endcase
    end

    done = 1;
    summary();
  end
endmodule